// File: doc/BRIEF.md
# AHB Delayed-Read Retry Controller

This block is the read path of an AHB slave that sits in front of slow or external targets reached through two user-side ports. A read that finds no matching data in the port's read buffer is not stalled. The block answers it with a two-cycle RETRY response and starts a read on that port's user interface in the background. The returned 32-bit words are captured into the port's buffer. When the master repeats the same read, the buffered words go back with no wait states, and the AHB bus stays free while the slow target works.

Each port can instead be set to real-time mode, meant for low-latency targets. In that mode a miss holds the bus with wait states until the fetch completes, and RETRY is never issued. Each port has its own buffer, and the port is selected by one address bit. The master may read bytes, halfwords or words; the block picks the byte lanes from the address and the transfer size. An AHB write that touches a buffered range invalidates that range.

Top module: `ahb_dread_ctrl`

## Requirements
- R1: In delayed mode (rt_mode bit 0 for the port), a read that misses is answered with RETRY (hresp = 2'b10) for two cycles. In the first cycle hreadyout is 0 and in the second it is 1. One user read is launched as a one-cycle u_req pulse, with u_addr equal to the word address haddr[ADDR_W-1:2].
- R2: While a port's fetch is outstanding, every read to that port is answered with RETRY, whether it has the same address or a different one, and no further u_req pulse is issued for that port.
- R3: Once all fetched words are captured, a read whose first beat (htrans = 2'b10) has the fetched start word address and whose length does not exceed the fetched length completes with hresp = 2'b00 and no wait state on any beat. Beat k carries the k-th word the user side returned.
- R4: In real-time mode (rt_mode bit 1), a miss inserts wait states (hreadyout = 0, hresp = 2'b00) until the data is captured, then delivers the data. RETRY is never issued.
- R5: Lane selection works as follows. For hsize = 0, only byte lane haddr[1:0] of the buffered word is driven and the other bits are 0. For hsize = 1, the halfword selected by haddr[1] is driven and the other half is 0. For hsize = 2, the whole word is driven.
- R6: The fetch length on u_len follows hburst of the missing access: 3'b011 gives 4 words, 3'b101 gives 8, 3'b111 gives 16, and any other code gives 1. Exactly that many u_rvalid beats are accepted.
- R7: Serving the last fetched word invalidates the buffer, so repeating the read afterwards misses again (RETRY in delayed mode plus a new u_req).
- R8: An AHB write to the same port whose word address lies inside the buffered range affects the buffer. If the data is captured, the buffer is emptied. If the fetch is still outstanding, the returning data is discarded. A write to the other port, or outside the range, leaves the buffer usable.
- R9: After reset, hreadyout = 1, hresp = 2'b00 and u_req = 0.
- R10: haddr[PORT_BIT] selects the port, and the ports are independent. A fetch outstanding on one port does not prevent the other port from launching its own fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hburst | input | 3 | Burst type, sets the fetch length |
| hready | input | 1 | Bus-level ready; address phase is taken when high |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 2 | Response: 2'b00 OKAY, 2'b10 RETRY |
| hrdata | output | 32 | Read data with lanes selected |
| rt_mode | input | 2 | Per-port mode: 1 real-time, 0 delayed |
| u_req | output | 2 | Per-port one-cycle fetch request |
| u_addr | output | 2*(ADDR_W-2) | Per-port fetch start word address |
| u_len | output | 2*($clog2(MAX_BEATS)+1) | Per-port fetch length in words |
| u_rvalid | input | 2 | Per-port returned-word strobe |
| u_rdata | input | 64 | Per-port returned word |

## Verification
Corrupted buffer state shows up at the ports within one access. A buffer that is wrongly held valid returns zero-wait data where a RETRY and a fresh u_req were due. A buffer that is wrongly dropped answers a repeated read with RETRY where zero-wait data was due. A wrong capture count or index shows up as a mismatch on a specific burst beat. A mistake in the pending flag appears either as an extra u_req during retries or as a port that retries forever. Extra wait states on a hit are counted beat by beat.

// File: rtl/ahb_dr_pkg.sv
package ahb_dr_pkg;
   localparam int DW = 32;

   typedef enum logic [1:0] {
      ENT_EMPTY = 2'd0,
      ENT_PEND  = 2'd1,
      ENT_FULL  = 2'd2
   } ent_st_e;

   localparam logic [1:0] RESP_OKAY  = 2'b00;
   localparam logic [1:0] RESP_RETRY = 2'b10;
   localparam logic [1:0] TR_NONSEQ  = 2'b10;
   localparam logic [1:0] TR_SEQ     = 2'b11;

   // words to fetch for a burst code, clamped to the buffer depth
   function automatic int unsigned burst_beats(input logic [2:0] hb, input int unsigned cap);
      int unsigned n;
      case (hb)
         3'b011:  n = 4;
         3'b101:  n = 8;
         3'b111:  n = 16;
         default: n = 1;
      endcase
      return (n > cap) ? cap : n;
   endfunction
endpackage

// File: rtl/ahb_dr_lane.sv
module ahb_dr_lane
   import ahb_dr_pkg::*;
(
   input  logic [DW-1:0] word_i,
   input  logic [1:0]    lane_i,
   input  logic [2:0]    size_i,
   output logic [DW-1:0] data_o
);
   always_comb begin
      case (size_i)
         3'd0:    data_o = word_i & (DW'(32'h0000_00FF) << {lane_i, 3'b000});
         3'd1:    data_o = word_i & (DW'(32'h0000_FFFF) << {lane_i[1], 4'b0000});
         default: data_o = word_i;
      endcase
   end
endmodule

// File: rtl/ahb_dr_rbuf.sv
module ahb_dr_rbuf
   import ahb_dr_pkg::*;
#(
   parameter int WA   = 14,
   parameter int MAXB = 16,
   localparam int LW  = $clog2(MAXB) + 1,
   localparam int IW  = $clog2(MAXB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch_i,
   input  logic [WA-1:0] base_i,
   input  logic [LW-1:0] len_i,
   input  logic          inval_i,
   input  logic          consume_i,
   input  logic [IW-1:0] rd_idx_i,
   output logic [DW-1:0] rd_data_o,
   output ent_st_e       st_o,
   output logic [WA-1:0] base_o,
   output logic [LW-1:0] len_o,
   output logic          u_req_o,
   output logic [WA-1:0] u_addr_o,
   output logic [LW-1:0] u_len_o,
   input  logic          u_rvalid_i,
   input  logic [DW-1:0] u_rdata_i
);
   ent_st_e       st;
   logic [WA-1:0] base;
   logic [LW-1:0] len;
   logic [LW-1:0] cnt;
   logic          stale;
   logic          take;
   logic [DW-1:0] mem [MAXB];

   assign take = (st == ENT_PEND) && u_rvalid_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ENT_EMPTY;
         base    <= '0;
         len     <= '0;
         cnt     <= '0;
         stale   <= 1'b0;
         u_req_o <= 1'b0;
      end else begin
         u_req_o <= launch_i;
         if (launch_i) begin
            st    <= ENT_PEND;
            base  <= base_i;
            len   <= len_i;
            cnt   <= '0;
            stale <= 1'b0;
         end else begin
            if (take) begin
               cnt <= cnt + LW'(1);
               if ((cnt + LW'(1)) == len)
                  st <= (stale || inval_i) ? ENT_EMPTY : ENT_FULL;
            end
            if (inval_i) begin
               if (st == ENT_FULL)      st    <= ENT_EMPTY;
               else if (st == ENT_PEND) stale <= 1'b1;
            end
            if (consume_i) st <= ENT_EMPTY;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) mem[cnt[IW-1:0]] <= u_rdata_i;
   end

   assign rd_data_o = mem[rd_idx_i];
   assign st_o      = st;
   assign base_o    = base;
   assign len_o     = len;
   assign u_addr_o  = base;
   assign u_len_o   = len;

   // R2
   fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |-> (st != ENT_PEND));
   // R6
   beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENT_PEND) |-> (cnt < len));
   // R1
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      u_req_o |=> !u_req_o);
endmodule

// File: rtl/ahb_dread_ctrl.sv
module ahb_dread_ctrl
   import ahb_dr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PORT_BIT  = 15,
   parameter int MAX_BEATS = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                hsel,
   input  logic [ADDR_W-1:0]                   haddr,
   input  logic [1:0]                          htrans,
   input  logic                                hwrite,
   input  logic [2:0]                          hsize,
   input  logic [2:0]                          hburst,
   input  logic                                hready,
   output logic                                hreadyout,
   output logic [1:0]                          hresp,
   output logic [31:0]                         hrdata,
   input  logic [1:0]                          rt_mode,
   output logic [1:0]                          u_req,
   output logic [2*(ADDR_W-2)-1:0]             u_addr,
   output logic [2*($clog2(MAX_BEATS)+1)-1:0]  u_len,
   input  logic [1:0]                          u_rvalid,
   input  logic [63:0]                         u_rdata
);
   localparam int WA = ADDR_W - 2;
   localparam int LW = $clog2(MAX_BEATS) + 1;
   localparam int IW = $clog2(MAX_BEATS);
   localparam int NP = 2;

   if (PORT_BIT < 2 || PORT_BIT >= ADDR_W) begin : g_bad_port
      $error("PORT_BIT must select a word-address bit");
   end
   if (MAX_BEATS != 4 && MAX_BEATS != 8 && MAX_BEATS != 16) begin : g_bad_beats
      $error("MAX_BEATS must be 4, 8 or 16");
   end

   // address phase
   logic          ap_go, wr_go, ap_port;
   logic [WA-1:0] ap_w;
   assign ap_go   = hsel && hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);
   assign wr_go   = ap_go && hwrite;
   assign ap_port = haddr[PORT_BIT];
   assign ap_w    = haddr[ADDR_W-1:2];

   // data phase registers
   logic          dp_rd, dp_port, dp_first, rty2;
   logic [WA-1:0] dp_w;
   logic [1:0]    dp_lane;
   logic [2:0]    dp_size;
   logic [LW-1:0] dp_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dp_rd    <= 1'b0;
         dp_port  <= 1'b0;
         dp_first <= 1'b0;
         dp_w     <= '0;
         dp_lane  <= '0;
         dp_size  <= '0;
         dp_len   <= '0;
      end else if (hready) begin
         dp_rd    <= ap_go && !hwrite;
         dp_port  <= ap_port;
         dp_first <= (htrans == TR_NONSEQ);
         dp_w     <= ap_w;
         dp_lane  <= haddr[1:0];
         dp_size  <= hsize;
         dp_len   <= LW'(burst_beats(hburst, MAX_BEATS));
      end
   end

   // per-port buffers
   ent_st_e       st  [NP];
   logic [WA-1:0] bse [NP];
   logic [LW-1:0] ln  [NP];
   logic [DW-1:0] rw  [NP];
   logic [NP-1:0] launch, inval, consume;
   logic [WA-1:0] off;
   logic [IW-1:0] rd_idx;

   assign off    = dp_w - bse[dp_port];
   assign rd_idx = off[IW-1:0];

   for (genvar g = 0; g < NP; g++) begin : g_port
      logic [WA-1:0] woff;
      assign woff = ap_w - bse[g];
      assign inval[g] = wr_go && (ap_port == 1'(g)) && (st[g] != ENT_EMPTY)
                        && (woff < WA'(ln[g]));

      ahb_dr_rbuf #(.WA(WA), .MAXB(MAX_BEATS)) u_buf (
         .clk        (clk),
         .rst_n      (rst_n),
         .launch_i   (launch[g]),
         .base_i     (dp_w),
         .len_i      (dp_len),
         .inval_i    (inval[g]),
         .consume_i  (consume[g]),
         .rd_idx_i   (rd_idx),
         .rd_data_o  (rw[g]),
         .st_o       (st[g]),
         .base_o     (bse[g]),
         .len_o      (ln[g]),
         .u_req_o    (u_req[g]),
         .u_addr_o   (u_addr[g*WA +: WA]),
         .u_len_o    (u_len[g*LW +: LW]),
         .u_rvalid_i (u_rvalid[g]),
         .u_rdata_i  (u_rdata[g*DW +: DW])
      );
   end

   // data-phase decision
   logic hit, serve, miss, retry1, launch_any;
   always_comb begin
      hit = (st[dp_port] == ENT_FULL) && (off < WA'(ln[dp_port]))
            && (!dp_first || (off == '0 && dp_len <= ln[dp_port]));
      serve      = dp_rd && !rty2 && hit;
      miss       = dp_rd && !rty2 && !hit;
      retry1     = miss && !rt_mode[dp_port];
      launch_any = miss && (st[dp_port] != ENT_PEND);
      for (int p = 0; p < NP; p++) begin
         launch[p]  = launch_any && (dp_port == 1'(p));
         consume[p] = serve && (dp_port == 1'(p)) && (off == WA'(ln[p] - LW'(1)));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rty2 <= 1'b0;
      else        rty2 <= retry1;
   end

   assign hreadyout = rty2 || !dp_rd || hit;
   assign hresp     = (rty2 || retry1) ? RESP_RETRY : RESP_OKAY;

   ahb_dr_lane u_lane (
      .word_i (rw[dp_port]),
      .lane_i (dp_lane),
      .size_i (dp_size),
      .data_o (hrdata)
   );

   // R1
   retry_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp == RESP_RETRY && !hreadyout) |=> (hresp == RESP_RETRY && hreadyout));
   // R1
   retry_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp == RESP_RETRY && hreadyout) |-> $past(hresp == RESP_RETRY && !hreadyout));
   // R4
   rt_noretry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rd && rt_mode[dp_port] && $stable(rt_mode)) |-> (hresp == RESP_OKAY));
endmodule

// File: tb/ahb_dread_ctrl_test.sv
`timescale 1ns/1ps
module ahb_dread_ctrl_test;
   localparam int LAT = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        hsel = 1'b0, hwrite = 1'b0, hready;
   logic [15:0] haddr = '0;
   logic [1:0]  htrans = '0;
   logic [2:0]  hsize = 3'd2, hburst = '0;
   logic        hreadyout;
   logic [1:0]  hresp;
   logic [31:0] hrdata;
   logic [1:0]  rt_mode = 2'b00;
   logic [1:0]  u_req;
   logic [27:0] u_addr;
   logic [9:0]  u_len;
   logic        rv0 = 1'b0, rv1 = 1'b0;
   logic [31:0] rd0 = '0, rd1 = '0;

   int nchk = 0, nbad = 0;
   int nl [2];
   int ll [2];
   logic [13:0] la [2];

   always #4 clk = ~clk;
   assign hready = hreadyout;

   ahb_dread_ctrl uut (
      .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hready(hready),
      .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata), .rt_mode(rt_mode),
      .u_req(u_req), .u_addr(u_addr), .u_len(u_len),
      .u_rvalid({rv1, rv0}), .u_rdata({rd1, rd0})
   );

   function automatic logic [31:0] ed(input logic [13:0] w);
      return ({18'd0, w} * 32'h0101_0103) ^ 32'h3C5A_9E17;
   endfunction

   function automatic int nb(input logic [2:0] hb);
      case (hb) 3'b011: return 4; 3'b101: return 8; 3'b111: return 16; default: return 1; endcase
   endfunction

   function automatic logic [2:0] code(input int b);
      case (b) 0: return 3'b000; 1: return 3'b011; 2: return 3'b101; default: return 3'b111; endcase
   endfunction

   function automatic logic [31:0] mk(input logic [31:0] w, input logic [1:0] ln, input logic [2:0] sz);
      if (sz == 3'd0) return w & (32'hFF << (8 * ln));
      if (sz == 3'd1) return w & (32'hFFFF << (16 * ln[1]));
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // user-side models
   initial begin : resp0
      nl[0] = 0; ll[0] = 0; la[0] = '0;
      forever begin
         @(negedge clk);
         if (u_req[0]) begin
            nl[0]++; la[0] = u_addr[13:0]; ll[0] = int'(u_len[4:0]);
            repeat (LAT) @(negedge clk);
            for (int k = 0; k < ll[0]; k++) begin rv0 = 1'b1; rd0 = ed(la[0] + 14'(k)); @(negedge clk); end
            rv0 = 1'b0;
         end
      end
   end
   initial begin : resp1
      nl[1] = 0; ll[1] = 0; la[1] = '0;
      forever begin
         @(negedge clk);
         if (u_req[1]) begin
            nl[1]++; la[1] = u_addr[27:14]; ll[1] = int'(u_len[9:5]);
            repeat (LAT) @(negedge clk);
            for (int k = 0; k < ll[1]; k++) begin rv1 = 1'b1; rd1 = ed(la[1] + 14'(k)); @(negedge clk); end
            rv1 = 1'b0;
         end
      end
   end

   task automatic rd(input logic [15:0] a, input logic [2:0] sz, input logic [2:0] hb,
                     output bit rty, output int waits, output logic [31:0] d [16]);
      int n;
      n = nb(hb); rty = 1'b0; waits = 0;
      for (int k = 0; k < 16; k++) d[k] = '0;
      @(negedge clk);
      hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = 1'b0; hsize = sz; hburst = hb;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k < n - 1) begin htrans = 2'b11; haddr = a + 16'(4 * (k + 1)); end
         else begin htrans = 2'b00; hsel = 1'b0; end
         while (!hreadyout && hresp == 2'b00) begin waits++; @(posedge clk); @(negedge clk); end
         if (hresp == 2'b10) begin
            chk(!hreadyout, "R1 retry cycle 1 hreadyout", 32'(hreadyout), 32'd0);
            htrans = 2'b00; hsel = 1'b0;
            @(posedge clk); @(negedge clk);
            chk(hreadyout && hresp == 2'b10, "R1 retry cycle 2", {30'd0, hresp} | 32'(hreadyout) << 8, 32'h102);
            rty = 1'b1;
            @(posedge clk);
            return;
         end
         d[k] = hrdata;
      end
   endtask

   task automatic wr(input logic [15:0] a);
      @(negedge clk);
      hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2; hburst = 3'b000;
      @(posedge clk); @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
      @(posedge clk);
   endtask

   task automatic idle(input int c);
      repeat (c) @(posedge clk);
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
   end

   initial begin : main
      bit r; int w; int n0, n1; logic [31:0] d [16];
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9
      chk(hreadyout == 1'b1, "R9 reset hreadyout", 32'(hreadyout), 32'd1);
      chk(hresp == 2'b00, "R9 reset hresp", 32'(hresp), 32'd0);
      chk(u_req == 2'b00, "R9 reset u_req", 32'(u_req), 32'd0);
      rst_n = 1'b1;
      idle(2);

      // delayed mode sweep over ports and burst codes
      rt_mode = 2'b00;
      for (int p = 0; p < 2; p++) begin
         for (int b = 0; b < 4; b++) begin
            logic [15:0] a; logic [2:0] hb; int n;
            hb = code(b); n = nb(hb);
            a = {p[0], 15'(b * 32'h0200)};
            n0 = nl[p];
            rd(a, 3'd2, hb, r, w, d);
            chk(r, "R1 miss retried", 32'(r), 32'd1);
            chk(nl[p] == n0 + 1, "R1 one user read", 32'(nl[p]), 32'(n0 + 1));
            chk(la[p] == a[15:2], "R1 user word address", 32'(la[p]), 32'(a[15:2]));
            chk(ll[p] == n, "R6 fetch length", 32'(ll[p]), 32'(n));
            rd(a, 3'd2, hb, r, w, d);
            chk(r && nl[p] == n0 + 1, "R2 same address while pending", 32'(nl[p]), 32'(n0 + 1));
            rd(a + 16'h0100, 3'd2, 3'b000, r, w, d);
            chk(r && nl[p] == n0 + 1, "R2 other address while pending", 32'(nl[p]), 32'(n0 + 1));
            idle(40);
            rd(a, 3'd2, hb, r, w, d);
            chk(!r, "R3 hit not retried", 32'(r), 32'd0);
            chk(w == 0, "R3 zero wait states", 32'(w), 32'd0);
            for (int k = 0; k < n; k++)
               chk(d[k] == ed(a[15:2] + 14'(k)), "R3 beat data", d[k], ed(a[15:2] + 14'(k)));
            rd(a, 3'd2, hb, r, w, d);
            chk(r && nl[p] == n0 + 2, "R7 consumed buffer misses", 32'(nl[p]), 32'(n0 + 2));
            idle(40);
            rd(a, 3'd2, hb, r, w, d);
            chk(!r, "R7 refetched data served", 32'(r), 32'd0);
         end
      end

      // lane selection, delayed on port 0 and real-time on port 1
      rt_mode = 2'b10;
      for (int s = 0; s < 2; s++) begin
         for (int l = 0; l < 4; l++) begin
            logic [15:0] a0, a1; logic [31:0] e;
            if (s == 1 && (l % 2) == 1) continue;
            a0 = 16'h1000 + 16'(l); a1 = 16'h9000 + 16'(l);
            rd(a0, 3'(s), 3'b000, r, w, d);
            chk(r, "R1 narrow miss retried", 32'(r), 32'd1);
            idle(20);
            rd(a0, 3'(s), 3'b000, r, w, d);
            e = mk(ed(a0[15:2]), a0[1:0], 3'(s));
            chk(!r && d[0] == e, "R5 lane data delayed", d[0], e);
            n1 = nl[1];
            rd(a1, 3'(s), 3'b000, r, w, d);
            e = mk(ed(a1[15:2]), a1[1:0], 3'(s));
            chk(!r && w > 0, "R4 waits instead of retry", 32'(w), 32'd1);
            chk(d[0] == e, "R5 lane data real-time", d[0], e);
            chk(nl[1] == n1 + 1, "R4 one user read", 32'(nl[1]), 32'(n1 + 1));
         end
      end
      begin
         logic [15:0] a1; a1 = 16'hA000;
         rd(a1, 3'd2, 3'b101, r, w, d);
         chk(!r && w > 0, "R4 burst waits without retry", 32'(r), 32'd0);
         for (int k = 0; k < 8; k++)
            chk(d[k] == ed(a1[15:2] + 14'(k)), "R4 burst data", d[k], ed(a1[15:2] + 14'(k)));
      end

      // write overlap
      rt_mode = 2'b00;
      rd(16'h0400, 3'd2, 3'b011, r, w, d);
      idle(40);
      wr(16'h8400);
      wr(16'h0440);
      rd(16'h0400, 3'd2, 3'b000, r, w, d);
      chk(!r && w == 0, "R8 unrelated writes keep buffer", 32'(r), 32'd0);
      chk(d[0] == ed(14'h0100), "R8 data after unrelated writes", d[0], ed(14'h0100));
      wr(16'h0408);
      n0 = nl[0];
      rd(16'h0400, 3'd2, 3'b000, r, w, d);
      chk(r && nl[0] == n0 + 1, "R8 overlapping write empties buffer", 32'(nl[0]), 32'(n0 + 1));
      idle(40);
      rd(16'h0400, 3'd2, 3'b000, r, w, d);
      rd(16'h0500, 3'd2, 3'b000, r, w, d);
      wr(16'h0500);
      idle(40);
      rd(16'h0500, 3'd2, 3'b000, r, w, d);
      chk(r, "R8 write during fetch discards data", 32'(r), 32'd1);
      idle(40);
      rd(16'h0500, 3'd2, 3'b000, r, w, d);

      // port independence
      n0 = nl[0]; n1 = nl[1];
      rd(16'h0600, 3'd2, 3'b000, r, w, d);
      rd(16'h8600, 3'd2, 3'b000, r, w, d);
      chk(nl[1] == n1 + 1 && nl[0] == n0 + 1, "R10 second port fetches while first pending", 32'(nl[1]), 32'(n1 + 1));
      idle(40);
      rd(16'h0600, 3'd2, 3'b000, r, w, d);
      chk(!r && d[0] == ed(14'h0180), "R10 port 0 hit", d[0], ed(14'h0180));
      rd(16'h8600, 3'd2, 3'b000, r, w, d);
      chk(!r && d[0] == ed(14'h2180), "R10 port 1 hit", d[0], ed(14'h2180));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
   end
endmodule